// File: doc/BRIEF.md
# Memory-mapped UART with FIFOs

This block is a serial port for 8-bit data. It has a transmit queue, a receive queue and four 32-bit registers on a simple single-cycle register bus. Software pushes bytes into the transmit queue by writing the transmit data register. It drains the receive queue by reading the receive data register. One control register holds:

- the transmit and receive enables,
- the two interrupt enables,
- two self-clearing queue flush bits,
- a 16-bit bit-period divider.

A status register reports queue fullness and emptiness, and whether each direction is idle.

The serial frame is one start bit (0), eight data bits sent least significant bit first, and one stop bit (1). The line rests high. The receiver passes the line through a two-stage synchronizer and waits for a high-to-low transition. It confirms the start bit half a bit period later, then samples one full bit period apart. Two level interrupt outputs flag a drained transmit queue and a non-empty receive queue.

Register offsets (byte addresses, decoded on address bits 3:2):

| Offset | Register |
|---|---|
| 0x0 | control |
| 0x4 | status |
| 0x8 | transmit data |
| 0xC | receive data |

Read data appears on `rdata` in the cycle after `rd_en`.

Top module: `mmio_uart`

## Requirements
- R1: After reset, the control register reads 0x00D90000 (divider 0xD9, all enables 0). The status register reads 0x0000003C. Both interrupt outputs are 0.
- R2: The control register fields sit at these bits: bit 0 transmit enable, bit 1 receive enable, bit 2 transmit-empty interrupt enable, bit 3 receive-non-empty interrupt enable, bits 31:16 divider. These fields read back as written. Bits 4 and 5 always read as 0.
- R3: Each frame on `txd` is: start bit 0, data bits 0 to 7, stop bit 1. Every bit lasts exactly divider clock cycles. `txd` is 1 between frames.
- R4: A write to the transmit data register queues its low 8 bits. Status bit 0 reads 1 once DEPTH bytes are queued. A write while the queue is full is dropped.
- R5: Status bit 2 is 1 when the transmit queue is empty. Status bit 4 is 1 only when that queue is empty and the last stop bit has been fully sent.
- R6: While transmit enable is 0, no new frame starts and queued bytes stay queued. A frame already in progress completes.
- R7: A read of the receive data register returns the oldest received byte in bits 7:0 and removes it from the queue. A read while the queue is empty (status bit 3 = 1) returns 0 and removes nothing.
- R8: A low pulse that is no longer low at the mid-bit check is rejected. The receiver then accepts the next valid frame.
- R9: A received frame whose stop bit samples 0 is discarded.
- R10: A frame that completes while the receive queue is full is discarded. Status bit 1 reads 1 when that queue is full.
- R11: While receive enable is 0, the line is ignored and status bit 5 (receive idle) stays 1.
- R12: Writing 1 to control bit 4 empties the transmit queue. Writing 1 to control bit 5 empties the receive queue.
- R13: `irq_tx` equals transmit-empty interrupt enable AND transmit queue empty. `irq_rx` equals receive-non-empty interrupt enable AND receive queue not empty. Each is registered one cycle behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| addr | input | AW | byte address of the register |
| wr_en | input | 1 | write strobe |
| wdata | input | 32 | write data |
| rd_en | input | 1 | read strobe |
| rdata | output | 32 | read data, valid the cycle after rd_en |
| rxd | input | 1 | serial input |
| txd | output | 1 | serial output |
| irq_tx | output | 1 | transmit queue drained interrupt |
| irq_rx | output | 1 | receive data available interrupt |

## Verification
The bench builds the block with DEPTH = 4, so both queues fill within a handful of frames. This brings the full flag and both drop-on-full paths into reach. The divider reset value 0xD9 is checked first. Then software sets the divider to 8, so a frame lasts 80 cycles and half-bit timing falls on whole cycles. The bench loops `txd` back to `rxd` for normal traffic. It drives hand-built frames to cover rejected start pulses, bad stop bits and a disabled receiver.

// File: rtl/mmio_uart_pkg.sv
package mmio_uart_pkg;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_TXD  = 2'd2;
  localparam logic [1:0] REG_RXD  = 2'd3;

  localparam int CB_TX_EN   = 0;
  localparam int CB_RX_EN   = 1;
  localparam int CB_IE_TX   = 2;
  localparam int CB_IE_RX   = 3;
  localparam int CB_TX_FLSH = 4;
  localparam int CB_RX_FLSH = 5;
  localparam int CB_DIV_LSB = 16;

  typedef enum logic [1:0] {
    SER_IDLE,
    SER_START,
    SER_DATA,
    SER_STOP
  } ser_state_t;
endpackage

// File: rtl/mu_fifo.sv
module mu_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      if (do_push && !do_pop)      cnt <= cnt + CW'(1);
      else if (do_pop && !do_push) cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/mu_tx.sv
module mu_tx
  import mmio_uart_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] div,
  input  logic          avail,
  input  logic [7:0]    data,
  output logic          pop,
  output logic          txd,
  output logic          busy
);
  localparam logic [DW:0] ONE = (DW + 1)'(1);

  ser_state_t    st;
  logic [DW-1:0] cnt;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic          bit_done;

  assign bit_done = ({1'b0, cnt} + ONE) >= {1'b0, div};
  assign pop      = (st == SER_IDLE) && en && avail;
  assign busy     = (st != SER_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SER_IDLE;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
      txd  <= 1'b1;
    end else begin
      unique case (st)
        SER_IDLE: begin
          cnt <= '0;
          if (pop) begin
            sh  <= data;
            txd <= 1'b0;
            st  <= SER_START;
          end
        end
        SER_START: begin
          if (bit_done) begin
            cnt  <= '0;
            txd  <= sh[0];
            sh   <= sh >> 1;
            bitn <= '0;
            st   <= SER_DATA;
          end else cnt <= cnt + DW'(1);
        end
        SER_DATA: begin
          if (bit_done) begin
            cnt <= '0;
            if (bitn == 3'd7) begin
              txd <= 1'b1;
              st  <= SER_STOP;
            end else begin
              txd  <= sh[0];
              sh   <= sh >> 1;
              bitn <= bitn + 3'd1;
            end
          end else cnt <= cnt + DW'(1);
        end
        SER_STOP: begin
          if (bit_done) begin
            cnt <= '0;
            st  <= SER_IDLE;
          end else cnt <= cnt + DW'(1);
        end
        default: st <= SER_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mu_rx.sv
module mu_rx
  import mmio_uart_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] div,
  input  logic          rxd,
  output logic          push,
  output logic [7:0]    data,
  output logic          idle
);
  localparam logic [DW:0] ONE = (DW + 1)'(1);

  ser_state_t    st;
  logic [DW-1:0] cnt;
  logic [2:0]    bitn;
  logic          s1, s2, s3;
  logic          bit_done, half_done;

  assign bit_done  = ({1'b0, cnt} + ONE) >= {1'b0, div};
  assign half_done = ({1'b0, cnt} + ONE) >= {2'b0, div[DW-1:1]};
  assign idle      = (st == SER_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      s3 <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SER_IDLE;
      cnt  <= '0;
      bitn <= '0;
      data <= '0;
      push <= 1'b0;
    end else begin
      push <= 1'b0;
      if (!en) begin
        st  <= SER_IDLE;
        cnt <= '0;
      end else begin
        unique case (st)
          SER_IDLE: begin
            cnt <= '0;
            if (s3 && !s2) st <= SER_START;
          end
          SER_START: begin
            if (half_done) begin
              cnt  <= '0;
              bitn <= '0;
              st   <= s2 ? SER_IDLE : SER_DATA;
            end else cnt <= cnt + DW'(1);
          end
          SER_DATA: begin
            if (bit_done) begin
              cnt  <= '0;
              data <= {s2, data[7:1]};
              if (bitn == 3'd7) st <= SER_STOP;
              else bitn <= bitn + 3'd1;
            end else cnt <= cnt + DW'(1);
          end
          SER_STOP: begin
            if (bit_done) begin
              cnt  <= '0;
              push <= s2;
              st   <= SER_IDLE;
            end else cnt <= cnt + DW'(1);
          end
          default: st <= SER_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
  import mmio_uart_pkg::*;
#(
  parameter int          DEPTH   = 16,
  parameter int          DIV_W   = 16,
  parameter logic [15:0] DIV_RST = 16'hD9,
  parameter int          AW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [31:0]   wdata,
  input  logic          rd_en,
  output logic [31:0]   rdata,
  input  logic          rxd,
  output logic          txd,
  output logic          irq_tx,
  output logic          irq_rx
);
  logic [1:0]       sel;
  logic             tx_en, rx_en, ie_tx, ie_rx;
  logic [DIV_W-1:0] div;
  logic             tx_flush, rx_flush, tx_push, rx_pop, wr_ctrl;
  logic             tx_pop, tx_empty, tx_full, tx_busy, tx_idle;
  logic             rx_push, rx_empty, rx_full, rx_idle;
  logic [7:0]       tx_dout, rx_din, rx_dout;
  logic [31:0]      rd_mux;
  logic             unused_bits;

  assign sel         = addr[3:2];
  assign unused_bits = ^{addr[1:0], wdata[15:8]};
  assign wr_ctrl     = wr_en && (sel == REG_CTRL);
  assign tx_flush    = wr_ctrl && wdata[CB_TX_FLSH];
  assign rx_flush    = wr_ctrl && wdata[CB_RX_FLSH];
  assign tx_push     = wr_en && (sel == REG_TXD);
  assign rx_pop      = rd_en && (sel == REG_RXD);
  assign tx_idle     = tx_empty && !tx_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_en <= 1'b0;
      rx_en <= 1'b0;
      ie_tx <= 1'b0;
      ie_rx <= 1'b0;
      div   <= DIV_W'(DIV_RST);
    end else if (wr_ctrl) begin
      tx_en <= wdata[CB_TX_EN];
      rx_en <= wdata[CB_RX_EN];
      ie_tx <= wdata[CB_IE_TX];
      ie_rx <= wdata[CB_IE_RX];
      div   <= wdata[CB_DIV_LSB +: DIV_W];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      REG_CTRL: begin
        rd_mux[CB_TX_EN]               = tx_en;
        rd_mux[CB_RX_EN]               = rx_en;
        rd_mux[CB_IE_TX]               = ie_tx;
        rd_mux[CB_IE_RX]               = ie_rx;
        rd_mux[CB_DIV_LSB +: DIV_W]    = div;
      end
      REG_STAT: rd_mux[5:0] = {rx_idle, tx_idle, rx_empty, tx_empty, rx_full, tx_full};
      REG_RXD:  rd_mux[7:0] = rx_empty ? 8'h00 : rx_dout;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      irq_tx <= 1'b0;
      irq_rx <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      irq_tx <= ie_tx && tx_empty;
      irq_rx <= ie_rx && !rx_empty;
    end
  end

  mu_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_flush), .push(tx_push), .din(wdata[7:0]),
    .pop(tx_pop), .dout(tx_dout), .empty(tx_empty), .full(tx_full)
  );

  mu_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(rx_flush), .push(rx_push), .din(rx_din),
    .pop(rx_pop), .dout(rx_dout), .empty(rx_empty), .full(rx_full)
  );

  mu_tx #(.DW(DIV_W)) u_tx (
    .clk(clk), .rst(rst), .en(tx_en), .div(div), .avail(!tx_empty),
    .data(tx_dout), .pop(tx_pop), .txd(txd), .busy(tx_busy)
  );

  mu_rx #(.DW(DIV_W)) u_rx (
    .clk(clk), .rst(rst), .en(rx_en), .div(div), .rxd(rxd),
    .push(rx_push), .data(rx_din), .idle(rx_idle)
  );
endmodule

// File: rtl/mmio_uart_chk.sv
module mmio_uart_chk (
  input logic clk,
  input logic rst,
  input logic txd,
  input logic tx_en,
  input logic tx_busy,
  input logic tx_idle,
  input logic tx_empty,
  input logic tx_full,
  input logic tx_flush,
  input logic rx_en,
  input logic rx_idle,
  input logic rx_empty,
  input logic rx_full,
  input logic rx_flush
);
  // R5
  tx_idle_line_chk: assert property (@(posedge clk) disable iff (rst)
    tx_idle |-> txd);

  // R4
  txq_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !(tx_full && tx_empty));

  // R10
  rxq_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !(rx_full && rx_empty));

  // R12
  tx_flush_chk: assert property (@(posedge clk) disable iff (rst)
    tx_flush |=> tx_empty);

  // R12
  rx_flush_chk: assert property (@(posedge clk) disable iff (rst)
    rx_flush |=> rx_empty);

  // R11
  rx_off_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> rx_idle);

  // R6
  tx_off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && !tx_busy) |=> !tx_busy);
endmodule

bind mmio_uart mmio_uart_chk u_chk (
  .clk(clk), .rst(rst), .txd(txd), .tx_en(tx_en), .tx_busy(tx_busy),
  .tx_idle(tx_idle), .tx_empty(tx_empty), .tx_full(tx_full), .tx_flush(tx_flush),
  .rx_en(rx_en), .rx_idle(rx_idle), .rx_empty(rx_empty), .rx_full(rx_full),
  .rx_flush(rx_flush)
);

// File: tb/mmio_uart_bench.sv
module mmio_uart_bench;
  localparam int DEPTH = 4;
  localparam int DIV   = 8;
  localparam logic [3:0] A_CTRL = 4'h0, A_STAT = 4'h4, A_TXD = 4'h8, A_RXD = 4'hC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        txd, irq_tx, irq_rx;
  logic        loop = 1'b1, line = 1'b1;
  logic        rxd;
  int          checks = 0, errors = 0;
  bit          done = 0;
  logic [7:0]  exp_q[$];

  assign rxd = loop ? txd : line;

  always #4 clk = ~clk;

  mmio_uart #(.DEPTH(DEPTH)) u_mmio_uart (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .rxd(rxd), .txd(txd),
    .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: queue the byte and record it as expected if it should arrive
  task automatic send(input logic [7:0] b, input bit kept);
    wr(A_TXD, {24'h0, b});
    if (kept) exp_q.push_back(b);
  endtask

  task automatic drive_frame(input logic [7:0] b, input logic stop);
    @(negedge clk);
    line = 1'b0;
    wait_cyc(DIV);
    for (int i = 0; i < 8; i++) begin
      line = b[i];
      wait_cyc(DIV);
    end
    line = stop;
    wait_cyc(DIV);
    line = 1'b1;
  endtask

  // monitor: pop every received byte and compare with the scoreboard
  task automatic drain(input string req);
    logic [31:0] st, d;
    rd(A_STAT, st);
    while (st[3] == 1'b0) begin
      rd(A_RXD, d);
      if (exp_q.size() == 0) chk(req, d, 32'hFFFF_FFFF);
      else chk(req, d, {24'h0, exp_q.pop_front()});
      rd(A_STAT, st);
    end
    chk(req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    bit          low_seen;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(2);

    // R1 reset state
    chk("R1 irq_tx", irq_tx, 0);
    chk("R1 irq_rx", irq_rx, 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 32'h00D9_0000);
    rd(A_STAT, v); chk("R1 status", v, 32'h0000_003C);

    // R2 fields read back, flush bits read 0
    wr(A_CTRL, 32'h0008_0033);
    rd(A_CTRL, v); chk("R2 ctrl", v, 32'h0008_0003);
    wr(A_CTRL, 32'h0008_000E);
    rd(A_CTRL, v); chk("R2 ctrl", v, 32'h0008_000E);
    wr(A_CTRL, 32'h0008_0003);

    // R3 frame shape on txd
    send(8'hA5, 1);
    while (txd !== 1'b0) @(negedge clk);
    wait_cyc(DIV / 2);
    chk("R3 start", txd, 0);
    for (int i = 0; i < 8; i++) begin
      wait_cyc(DIV);
      chk("R3 data", txd, 32'(v[0] & 1'b0) | 32'((8'hA5 >> i) & 8'h1));
    end
    wait_cyc(DIV);
    chk("R3 stop", txd, 1);
    wait_cyc(DIV);
    chk("R3 idle", txd, 1);

    // R5 queue empty while still shifting, then idle
    send(8'h3C, 1);
    wait_cyc(3);
    rd(A_STAT, v); chk("R5 shifting", v & 32'h14, 32'h04);
    wait_cyc(100);
    rd(A_STAT, v); chk("R5 done", v & 32'h14, 32'h14);
    drain("R7 loopback");

    // R7 empty read
    rd(A_RXD, v); chk("R7 empty read", v, 0);
    rd(A_STAT, v); chk("R7 still empty", v[3], 1);

    // R4 / R6 fill with transmitter off
    wr(A_CTRL, 32'h0008_0002);
    send(8'h11, 1); send(8'h22, 1); send(8'h33, 1); send(8'h44, 1);
    send(8'h55, 0);
    rd(A_STAT, v); chk("R4 full", v[0], 1);
    low_seen = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (txd == 1'b0) low_seen = 1;
    end
    chk("R6 no start", low_seen, 0);
    wr(A_CTRL, 32'h0008_0003);
    wait_cyc(400);
    rd(A_STAT, v); chk("R10 rx full", v & 32'h12, 32'h12);
    send(8'h66, 0);
    wait_cyc(100);
    drain("R10 drop when full");

    // R6 frame in progress completes, next stays queued
    send(8'h5A, 1);
    send(8'h77, 0);
    while (txd !== 1'b0) @(negedge clk);
    wr(A_CTRL, 32'h0008_0002);
    wait_cyc(120);
    rd(A_STAT, v); chk("R6 queued kept", v[2], 0);
    drain("R6 finish frame");

    // R12 transmit flush
    wr(A_CTRL, 32'h0008_0012);
    rd(A_STAT, v); chk("R12 tx flush", v & 32'h14, 32'h14);
    wr(A_CTRL, 32'h0008_0003);
    wait_cyc(100);
    rd(A_STAT, v); chk("R12 nothing sent", v[3], 1);

    // R12 receive flush
    send(8'h99, 0);
    wait_cyc(100);
    rd(A_STAT, v); chk("R12 rx has data", v[3], 0);
    wr(A_CTRL, 32'h0008_0023);
    rd(A_STAT, v); chk("R12 rx flush", v[3], 1);
    drain("R12 rx flush");

    // R8 short low pulse, then a good frame
    loop = 1'b0;
    @(negedge clk); line = 1'b0;
    wait_cyc(2);
    line = 1'b1;
    wait_cyc(40);
    rd(A_STAT, v); chk("R8 glitch", v & 32'h28, 32'h28);
    drive_frame(8'hC3, 1'b1);
    exp_q.push_back(8'hC3);
    wait_cyc(10);
    drain("R8 recovery");

    // R9 bad stop bit
    drive_frame(8'h81, 1'b0);
    wait_cyc(20);
    rd(A_STAT, v); chk("R9 bad stop", v[3], 1);

    // R11 receiver disabled
    wr(A_CTRL, 32'h0008_0001);
    fork
      drive_frame(8'hE7, 1'b1);
      begin
        wait_cyc(30);
        rd(A_STAT, v); chk("R11 rx idle", v[5], 1);
      end
    join
    wait_cyc(20);
    wr(A_CTRL, 32'h0008_0003);
    rd(A_STAT, v); chk("R11 ignored", v[3], 1);
    loop = 1'b1;

    // R13 interrupts
    wr(A_CTRL, 32'h0008_000F);
    wait_cyc(2);
    chk("R13 irq_tx", irq_tx, 1);
    chk("R13 irq_rx idle", irq_rx, 0);
    send(8'h42, 1);
    wait_cyc(110);
    chk("R13 irq_rx set", irq_rx, 1);
    drain("R13 data");
    wait_cyc(2);
    chk("R13 irq_rx clear", irq_rx, 0);
    wr(A_CTRL, 32'h0008_0003);
    wait_cyc(2);
    chk("R13 irq_tx off", irq_tx, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule